// File: doc/BRIEF.md
# Adaptive Break-Before-Make Gate Sequencer

This block converts a single pulse-width command into two gate-enable outputs for a half-bridge: one for the upper switch and one for the lower switch. It makes sure the two switches never conduct together. Dead time is not a fixed delay. It depends on two threshold flags from external comparators. The first flag reports that the switch node has dropped below its threshold. The second flag reports that the lower gate voltage has dropped below its threshold. The sequencer releases the opposite side only after the matching flag confirms that the previous side has discharged.

If the switch node never falls after the upper side turns off, a timeout turns the lower side on anyway. The lower side then stays on until the command next changes. A shutdown request (from undervoltage or overtemperature monitoring) or a tri-state-detect flag forces both enables low. When that condition clears, the block restarts from an idle state with both enables off.

The command and both flags pass through a multi-stage synchronizer before they are used. Propagation delays and the timeout are parameters counted in clock cycles.

Top module: `bbm_gate_sequencer`

## Requirements
- R1: In steady state the logic is noninverting. A high command gives upper enable 1 and lower enable 0. A low command (with the switch-node flag seen) gives upper 0 and lower 1.
- R2: On a falling command the upper enable drops first. If the switch-node flag is already true, the lower enable rises exactly PROP_CYC+1 cycles after the upper enable falls.
- R3: After the upper enable falls, the lower enable stays low while the switch-node flag is false and the timeout has not expired. It rises once the flag becomes true.
- R4: On a rising command the lower enable drops first. If the lower-gate flag is already true, the upper enable rises exactly PROP_CYC+1 cycles after the lower enable falls.
- R5: The upper enable never rises while the lower-gate flag stays false.
- R6: If the switch-node flag stays false, the lower enable is forced high exactly TMO_CYC cycles after the upper enable falls. It then stays high, whatever the flag does, until the command rises.
- R7: A shutdown request forces both enables low one clock edge after it is sampled. When the request is released, the block resumes from the current command level.
- R8: An active tri-state-detect flag forces both enables low. When the flag clears, the block resumes from the current command level.
- R9: If the command reverses while the block waits for a threshold flag, the pending turn-on is abandoned and the side that was waiting never asserts.
- R10: The two enables are never high in the same cycle.
- R11: While reset is active, both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Switching command, high requests the upper side |
| shutdown_i | input | 1 | Shutdown request from supply or thermal monitors |
| tristate_i | input | 1 | Tri-state-detect flag, high forces both sides off |
| sw_low_i | input | 1 | Switch node below threshold (asynchronous) |
| lsg_low_i | input | 1 | Lower gate below threshold (asynchronous) |
| hs_en_o | output | 1 | Upper-side gate enable |
| ls_en_o | output | 1 | Lower-side gate enable |

## Verification
The hardest situations to reach are the forced lower-side turn-on and the abandoned turn-on after a command reversal. Both need the comparator flags held against the command for a long time. The stimulus holds the switch-node flag false through the whole timeout window and measures the gap from the upper enable falling to the forced lower turn-on. It then toggles the flag to show that the forced state holds. For the reversal case, the command is flipped while the block sits in the switch-node wait, and the bench confirms that the lower enable never rose.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HS_ON,
    ST_HS_OFF_DLY,
    ST_WAIT_SW,
    ST_LS_DLY,
    ST_LS_ON,
    ST_LS_FORCED,
    ST_LS_OFF_DLY,
    ST_WAIT_LSG,
    ST_HS_DLY
  } bbm_state_e;
endpackage

// File: rtl/bbm_sync.sv
module bbm_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bbm_timer.sv
module bbm_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt, cnt_n;
  logic          cen;

  always_comb begin
    cen   = load_i || (cnt != '0);
    cnt_n = load_i ? val_i : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (cen) cnt <= cnt_n;
  end

  assign done_o = (cnt == '0);

  // R6
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt == $past(val_i)));
endmodule

// File: rtl/bbm_fsm.sv
module bbm_fsm
  import bbm_pkg::*;
#(
  parameter int CW       = 6,
  parameter int PROP_CYC = 2,
  parameter int TMO_CYC  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_s,
  input  logic          sw_low_s,
  input  logic          lsg_low_s,
  input  logic          shutdown_i,
  input  logic          tristate_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          hs_en_o,
  output logic          ls_en_o
);
  localparam logic [CW-1:0] PROP_LD = CW'(PROP_CYC - 1);
  localparam logic [CW-1:0] TMO_LD  = CW'(TMO_CYC - 1);

  bbm_state_e state, state_n;
  logic       block;

  assign block = shutdown_i || tristate_i;

  always_comb begin
    state_n    = state;
    tmr_load_o = 1'b0;
    tmr_val_o  = PROP_LD;
    if (block) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pwm_s) state_n = ST_WAIT_LSG;
          else begin
            state_n = ST_WAIT_SW; tmr_load_o = 1'b1; tmr_val_o = TMO_LD;
          end
        end
        ST_HS_ON: begin
          if (!pwm_s) begin state_n = ST_HS_OFF_DLY; tmr_load_o = 1'b1; end
        end
        ST_HS_OFF_DLY: begin
          if (pwm_s) state_n = ST_HS_ON;
          else if (tmr_done_i) begin
            state_n = ST_WAIT_SW; tmr_load_o = 1'b1; tmr_val_o = TMO_LD;
          end
        end
        ST_WAIT_SW: begin
          if (pwm_s) state_n = ST_WAIT_LSG;
          else if (sw_low_s) begin state_n = ST_LS_DLY; tmr_load_o = 1'b1; end
          else if (tmr_done_i) state_n = ST_LS_FORCED;
        end
        ST_LS_DLY: begin
          if (pwm_s) state_n = ST_WAIT_LSG;
          else if (tmr_done_i) state_n = ST_LS_ON;
        end
        ST_LS_ON, ST_LS_FORCED: begin
          if (pwm_s) begin state_n = ST_LS_OFF_DLY; tmr_load_o = 1'b1; end
        end
        ST_LS_OFF_DLY: begin
          if (!pwm_s) state_n = ST_LS_ON;
          else if (tmr_done_i) state_n = ST_WAIT_LSG;
        end
        ST_WAIT_LSG: begin
          if (!pwm_s) begin
            state_n = ST_WAIT_SW; tmr_load_o = 1'b1; tmr_val_o = TMO_LD;
          end else if (lsg_low_s) begin
            state_n = ST_HS_DLY; tmr_load_o = 1'b1;
          end
        end
        ST_HS_DLY: begin
          if (!pwm_s) begin
            state_n = ST_WAIT_SW; tmr_load_o = 1'b1; tmr_val_o = TMO_LD;
          end else if (tmr_done_i) state_n = ST_HS_ON;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  assign hs_en_o = (state == ST_HS_ON) || (state == ST_HS_OFF_DLY);
  assign ls_en_o = (state == ST_LS_ON) || (state == ST_LS_FORCED) ||
                   (state == ST_LS_OFF_DLY);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o));
  // R7
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (!hs_en_o && !ls_en_o));
  // R8
  tristate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tristate_i |=> (!hs_en_o && !ls_en_o));
  // R4
  hs_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> (!$past(ls_en_o) && !$past(ls_en_o, 2)));
  // R2
  ls_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en_o) |-> (!$past(hs_en_o) && !$past(hs_en_o, 2)));
  // R6
  forced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LS_FORCED && !pwm_s && !block) |=> ls_en_o);
endmodule

// File: rtl/bbm_gate_sequencer.sv
module bbm_gate_sequencer #(
  parameter int PROP_CYC    = 2,
  parameter int TMO_CYC     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic shutdown_i,
  input  logic tristate_i,
  input  logic sw_low_i,
  input  logic lsg_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int MAXV = (TMO_CYC > PROP_CYC) ? TMO_CYC : PROP_CYC;
  localparam int CW   = $clog2(MAXV + 1);

  logic [2:0]    raw, synced;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  assign raw = {pwm_i, sw_low_i, lsg_low_i};

  bbm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  bbm_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
    .done_o(tmr_done)
  );

  bbm_fsm #(.CW(CW), .PROP_CYC(PROP_CYC), .TMO_CYC(TMO_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pwm_s(synced[2]), .sw_low_s(synced[1]), .lsg_low_s(synced[0]),
    .shutdown_i(shutdown_i), .tristate_i(tristate_i),
    .tmr_done_i(tmr_done), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );
endmodule

// File: tb/tb_bbm_gate_sequencer.sv
module tb_bbm_gate_sequencer;
  localparam int PROP = 2;
  localparam int TMO  = 40;

  logic clk = 1'b0;
  logic rst_n, pwm, sd, ts, sw, lsg;
  logic hs, ls;
  int   checks = 0, errors = 0, overlaps = 0, cycles = 0;
  bit   ls_seen = 1'b0;

  always #5 clk = ~clk;

  bbm_gate_sequencer #(.PROP_CYC(PROP), .TMO_CYC(TMO), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .shutdown_i(sd), .tristate_i(ts),
    .sw_low_i(sw), .lsg_low_i(lsg), .hs_en_o(hs), .ls_en_o(ls)
  );

  // bits: {shutdown, tristate, pwm, sw_flag, lsg_flag, exp_hs, exp_ls}
  localparam logic [6:0] VECS [12] = '{
    7'b0010110, 7'b0001001, 7'b0010000, 7'b0010110,
    7'b1010100, 7'b0010110, 7'b0101000, 7'b0001001,
    7'b0000001, 7'b0010110, 7'b0000001, 7'b0001001
  };

  function automatic string row_req(int i);
    case (i)
      0, 1, 3: return "R1";
      2:       return "R5";
      4:       return "R7";
      5:       return "R7 resume";
      6:       return "R8";
      7:       return "R8 resume";
      8:       return "R3 flag drop";
      9:       return "R1 again";
      10, 11:  return "R6";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n && hs && ls) overlaps++;
    if (ls) ls_seen = 1'b1;
  end

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hs,ls} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_n(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for the first enable to fall, then counts cycles until the other rises
  task automatic gap_after(input bit hs_first, output int n);
    int guard = 0;
    while ((hs_first ? hs : ls) && guard < 500) begin @(negedge clk); guard++; end
    n = 0;
    while (!(hs_first ? ls : hs) && n < 500) begin n++; @(negedge clk); end
  endtask

  initial begin
    int g;
    rst_n = 1'b0; pwm = 1'b0; sd = 1'b0; ts = 1'b0; sw = 1'b0; lsg = 1'b0;
    settle(5);
    chk("R11 reset", {hs, ls}, 2'b00);
    pwm = 1'b1; settle(3);
    chk("R11 reset held", {hs, ls}, 2'b00);
    pwm = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      {sd, ts, pwm, sw, lsg} = VECS[i][6:2];
      settle(60);
      chk(row_req(i), {hs, ls}, VECS[i][1:0]);
    end
    sd = 1'b0; ts = 1'b0;

    // R4: rising gap with lower gate flag already true
    lsg = 1'b1; pwm = 1'b1;
    gap_after(1'b0, g);
    chk_n("R4 gap", g, PROP + 1);
    // R2: falling gap with switch-node flag already true
    sw = 1'b1; pwm = 1'b0;
    gap_after(1'b1, g);
    chk_n("R2 gap", g, PROP + 1);

    // R3: lower side waits on the switch-node flag
    pwm = 1'b1; settle(20);
    sw = 1'b0; pwm = 1'b0; settle(20);
    chk("R3 waiting", {hs, ls}, 2'b00);
    sw = 1'b1; settle(10);
    chk("R3 flag seen", {hs, ls}, 2'b01);

    // R6: timeout window and hold
    pwm = 1'b1; settle(20);
    sw = 1'b0; pwm = 1'b0;
    gap_after(1'b1, g);
    chk_n("R6 timeout gap", g, TMO);
    sw = 1'b1; settle(10); sw = 1'b0; settle(60);
    chk("R6 forced held", {hs, ls}, 2'b01);
    pwm = 1'b1;
    gap_after(1'b0, g);
    chk_n("R6 release on rise", g, PROP + 1);

    // R9: reversal during switch-node wait
    settle(10);
    sw = 1'b0; pwm = 1'b0; settle(10);
    ls_seen = 1'b0;
    pwm = 1'b1; settle(20);
    chk("R9 back to upper", {hs, ls}, 2'b10);
    chk_n("R9 lower never on", int'(ls_seen), 0);

    // R7: one-edge shutdown response
    sd = 1'b1; @(negedge clk);
    chk("R7 immediate", {hs, ls}, 2'b00);
    sd = 1'b0; settle(20);
    chk("R7 resume", {hs, ls}, 2'b10);

    chk_n("R10 overlap cycles", overlaps, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule